// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block resolves data hazards for a five-stage in-order integer pipeline whose stages run in the order fetch, decode, execute, memory, write-back, with one instruction entering per cycle. It compares the two source register numbers of the instruction in execute with the destination numbers held in the EX/MEM and MEM/WB pipeline registers. From that comparison it drives the select lines of the two ALU operand multiplexers. Each multiplexer chooses between the register-file value, the EX/MEM result and the MEM/WB result.

A load delivers its data only at the end of the memory stage, so that data cannot be bypassed to a consumer that directly follows the load. The unit detects this case from the decode-stage source numbers and the execute-stage load flag. It then holds the PC and the IF/ID register and loads an all-zero control word into ID/EX. One bubble is enough: after it, the loaded value reaches the consumer through the MEM/WB path.

A two-read, one-write register file sits beside the control logic. Reads happen in decode and the write happens in write-back. A read of a register that is being written in the same cycle returns the new value.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A select line reads 2'b10 (EX/MEM result) when the EX/MEM destination equals that operand's execute-stage source, the EX/MEM write enable is 1 and the destination is not register 0.
- R2: A select line reads 2'b01 (MEM/WB result) when the MEM/WB destination equals that operand's source, the MEM/WB write enable is 1, the destination is not register 0, and R1 does not apply.
- R3: When both EX/MEM and MEM/WB qualify for the same operand, the select is 2'b10, because EX/MEM holds the younger result.
- R4: The select reads 2'b00 (register file) when neither stage qualifies, which includes every case where the matching stage has its write enable at 0 or the source is register 0.
- R5: pc_hold, ifid_hold and idex_bubble are all 1 exactly when the execute-stage instruction is a load with write enable 1, its destination is not register 0, and that destination equals either decode-stage source; otherwise all three are 0.
- R6: A load followed directly by a dependent instruction costs exactly one stall cycle. Once the bubble sits in execute and the load is in memory, no stall is raised. One cycle later the consumer in execute selects the MEM/WB result (2'b01).
- R7: A read port addressing a nonzero register that the write port writes in the same cycle returns the write data.
- R8: Register 0 reads as zero on both ports, even after a write to it and even during a same-cycle write to it.
- R9: A value written to a nonzero register is returned by later reads until it is overwritten, and every register reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the register file |
| id_rs1 | input | 5 | Decode-stage first source register / read port 1 address |
| id_rs2 | input | 5 | Decode-stage second source register / read port 2 address |
| ex_rs1 | input | 5 | Execute-stage first source register (operand A) |
| ex_rs2 | input | 5 | Execute-stage second source register (operand B) |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage register write enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | EX/MEM destination register |
| mem_wen | input | 1 | EX/MEM register write enable |
| wb_rd | input | 5 | MEM/WB destination register, also the write port address |
| wb_wen | input | 1 | MEM/WB write enable, also the write port enable |
| wb_data | input | 32 | Write-back data |
| rf_rdata1 | output | 32 | Read port 1 data |
| rf_rdata2 | output | 32 | Read port 2 data |
| fwd_sel_a | output | 2 | Operand A select: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_sel_b | output | 2 | Operand B select, same encoding |
| pc_hold | output | 1 | Hold the PC this cycle |
| ifid_hold | output | 1 | Hold the IF/ID register this cycle |
| idex_bubble | output | 1 | Load an all-zero control word into ID/EX |

## Verification
The select lines and stall outputs are combinational, so a wrong comparison or a wrong priority shows on fwd_sel_a, fwd_sel_b or the hold lines in the same cycle as the input pattern that triggers it. If the register file holds a wrong value, the error shows only when that register is next read, which can be many cycles after the write. For that reason the stimulus draws register numbers from a small range, so reads often follow writes to the same register. A missing write-through path shows up only in the cycle where the read and the write address coincide.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
    parameter int XLEN_DEF  = 32;
    parameter int NREGS_DEF = 32;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hfu_fwd_select.sv
module hfu_fwd_select
    import hfu_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output fwd_sel_e      sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_wen && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);
        if (mem_hit) begin
            sel = SEL_MEM;
        end else if (wb_hit) begin
            sel = SEL_WB;
        end else begin
            sel = SEL_RF;
        end
    end
endmodule

// File: rtl/hfu_load_use.sv
module hfu_load_use #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    output logic          stall
);
    logic producer;

    always_comb begin
        producer = ex_load && ex_wen && (ex_rd != '0);
        stall    = producer && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
    end
endmodule

// File: rtl/hfu_regfile.sv
module hfu_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    input  logic [AW-1:0]   wa,
    input  logic            wen,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata1,
    output logic [XLEN-1:0] rdata2
);
    typedef struct packed {
        logic [NREGS-1:0][XLEN-1:0] regs;
    } rf_state_t;

    rf_state_t state_d;
    rf_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (wen && (wa != '0)) begin
            state_d.regs[wa] = wdata;
        end
        state_d.regs[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    logic [1:0][AW-1:0]   raddr;
    logic [1:0][XLEN-1:0] rdata;

    assign raddr[0] = ra1;
    assign raddr[1] = ra2;

    for (genvar p = 0; p < 2; p++) begin : g_rport
        always_comb begin
            if (raddr[p] == '0) begin
                rdata[p] = '0;
            end else if (wen && (wa == raddr[p])) begin
                rdata[p] = wdata;
            end else begin
                rdata[p] = state_q.regs[raddr[p]];
            end
        end
    end

    assign rdata1 = rdata[0];
    assign rdata2 = rdata[1];
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hfu_pkg::*;
#(
    parameter int XLEN  = XLEN_DEF,
    parameter int NREGS = NREGS_DEF,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   id_rs1,
    input  logic [AW-1:0]   id_rs2,
    input  logic [AW-1:0]   ex_rs1,
    input  logic [AW-1:0]   ex_rs2,
    input  logic [AW-1:0]   ex_rd,
    input  logic            ex_wen,
    input  logic            ex_load,
    input  logic [AW-1:0]   mem_rd,
    input  logic            mem_wen,
    input  logic [AW-1:0]   wb_rd,
    input  logic            wb_wen,
    input  logic [XLEN-1:0] wb_data,
    output logic [XLEN-1:0] rf_rdata1,
    output logic [XLEN-1:0] rf_rdata2,
    output logic [1:0]      fwd_sel_a,
    output logic [1:0]      fwd_sel_b,
    output logic            pc_hold,
    output logic            ifid_hold,
    output logic            idex_bubble
);
    localparam int NOPS = 2;

    logic [NOPS-1:0][AW-1:0] ex_src;
    fwd_sel_e                sel [NOPS];
    logic                    stall;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar k = 0; k < NOPS; k++) begin : g_operand
        hfu_fwd_select #(.AW(AW)) u_sel (
            .src     (ex_src[k]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (sel[k])
        );
    end

    assign fwd_sel_a = sel[0];
    assign fwd_sel_b = sel[1];

    hfu_load_use #(.AW(AW)) u_load_use (
        .id_rs1  (id_rs1),
        .id_rs2  (id_rs2),
        .ex_rd   (ex_rd),
        .ex_wen  (ex_wen),
        .ex_load (ex_load),
        .stall   (stall)
    );

    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;

    hfu_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra1    (id_rs1),
        .ra2    (id_rs2),
        .wa     (wb_rd),
        .wen    (wb_wen),
        .wdata  (wb_data),
        .rdata1 (rf_rdata1),
        .rdata2 (rf_rdata2)
    );
endmodule

// File: rtl/hfu_chk.sv
module hfu_chk
    import hfu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   id_rs1,
    input logic [AW-1:0]   id_rs2,
    input logic [AW-1:0]   ex_rs1,
    input logic [AW-1:0]   ex_rs2,
    input logic [AW-1:0]   ex_rd,
    input logic            ex_wen,
    input logic            ex_load,
    input logic [AW-1:0]   mem_rd,
    input logic            mem_wen,
    input logic [AW-1:0]   wb_rd,
    input logic            wb_wen,
    input logic [XLEN-1:0] wb_data,
    input logic [XLEN-1:0] rf_rdata1,
    input logic [XLEN-1:0] rf_rdata2,
    input logic [1:0]      fwd_sel_a,
    input logic [1:0]      fwd_sel_b,
    input logic            pc_hold,
    input logic            ifid_hold,
    input logic            idex_bubble
);
    logic lu_hazard;
    assign lu_hazard = ex_load && ex_wen && (ex_rd != '0) &&
                       ((ex_rd == id_rs1) || (ex_rd == id_rs2));

    // R1 R3
    mem_fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && (mem_rd != '0) && (mem_rd == ex_rs1)) |-> (fwd_sel_a == SEL_MEM));

    // R2
    wb_fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wen && (wb_rd != '0) && (wb_rd == ex_rs2) &&
         !(mem_wen && (mem_rd == ex_rs2))) |-> (fwd_sel_b == SEL_WB));

    // R4
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (fwd_sel_a == SEL_RF));

    // R5
    stall_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold == lu_hazard);

    // R5
    stall_ifid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_hold == lu_hazard);

    // R5
    stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble == lu_hazard);

    // R8
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((id_rs1 == '0) |-> (rf_rdata1 == '0)) and ((id_rs2 == '0) |-> (rf_rdata2 == '0)));

    // R9
    write_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wb_wen) && ($past(wb_rd) != '0) &&
         (id_rs1 == $past(wb_rd)) && !(wb_wen && (wb_rd == id_rs1)))
        |-> (rf_rdata1 == $past(wb_data)));
endmodule

bind hazard_fwd_unit hfu_chk #(.XLEN(XLEN), .NREGS(NREGS)) u_chk (.*);

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int AW    = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic            ex_wen = 1'b0, ex_load = 1'b0;
    logic [AW-1:0]   mem_rd = '0;
    logic            mem_wen = 1'b0;
    logic [AW-1:0]   wb_rd = '0;
    logic            wb_wen = 1'b0;
    logic [XLEN-1:0] wb_data = '0;
    logic [XLEN-1:0] rf_rdata1, rf_rdata2;
    logic [1:0]      fwd_sel_a, fwd_sel_b;
    logic            pc_hold, ifid_hold, idex_bubble;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [XLEN-1:0] model [NREGS];

    always #5 clk = ~clk;

    hazard_fwd_unit #(.XLEN(XLEN), .NREGS(NREGS)) u_dut (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
        .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd),
        .wb_wen(wb_wen), .wb_data(wb_data), .rf_rdata1(rf_rdata1),
        .rf_rdata2(rf_rdata2), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    function automatic logic [1:0] exp_sel(logic [AW-1:0] s);
        if (mem_wen && mem_rd != 0 && mem_rd == s) return 2'b10;
        if (wb_wen && wb_rd != 0 && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_stall();
        return ex_load && ex_wen && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    endfunction

    function automatic logic [XLEN-1:0] exp_rd(logic [AW-1:0] a);
        if (a == 0) return '0;
        if (wb_wen && wb_rd == a) return wb_data;
        return model[a];
    endfunction

    task automatic cmp(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Sample all outputs against the bench model, then clock once.
    task automatic check_all(string req);
        #1;
        cmp({req, " sel_a"}, XLEN'(fwd_sel_a), XLEN'(exp_sel(ex_rs1)));
        cmp({req, " sel_b"}, XLEN'(fwd_sel_b), XLEN'(exp_sel(ex_rs2)));
        cmp({req, " pc_hold"}, XLEN'(pc_hold), XLEN'(exp_stall()));
        cmp({req, " ifid_hold"}, XLEN'(ifid_hold), XLEN'(exp_stall()));
        cmp({req, " idex_bubble"}, XLEN'(idex_bubble), XLEN'(exp_stall()));
        cmp({req, " rdata1"}, rf_rdata1, exp_rd(id_rs1));
        cmp({req, " rdata2"}, rf_rdata2, exp_rd(id_rs2));
        @(posedge clk);
        if (wb_wen && wb_rd != 0) model[wb_rd] = wb_data;
        @(negedge clk);
    endtask

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        ex_wen = 0; ex_load = 0; mem_rd = 0; mem_wen = 0;
        wb_rd = 0; wb_wen = 0; wb_data = 0;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state, every register zero
        for (int r = 0; r < NREGS; r += 2) begin
            idle(); id_rs1 = AW'(r); id_rs2 = AW'(r + 1);
            check_all("R9 reset");
        end

        // R1 R2 R3: priority when both stages match
        idle(); ex_rs1 = 5; ex_rs2 = 5; mem_rd = 5; mem_wen = 1; wb_rd = 5; wb_wen = 1; wb_data = 32'h11;
        check_all("R3 both match");
        idle(); ex_rs1 = 6; ex_rs2 = 7; mem_rd = 6; mem_wen = 1; wb_rd = 7; wb_wen = 1; wb_data = 32'h22;
        check_all("R1 R2 split");
        // R4: enable low and register 0
        idle(); ex_rs1 = 6; ex_rs2 = 7; mem_rd = 6; mem_wen = 0; wb_rd = 7; wb_wen = 0;
        check_all("R4 no enable");
        idle(); ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1; wb_data = 32'hdead;
        check_all("R4 R8 reg zero");
        idle(); id_rs1 = 0; id_rs2 = 0;
        check_all("R8 zero after write");

        // R5 R6: load-use sequence
        idle(); ex_rd = 9; ex_wen = 1; ex_load = 1; id_rs2 = 9;
        check_all("R5 R6 load-use stall");
        idle(); ex_rd = 9; ex_wen = 1; ex_load = 0; id_rs1 = 9;
        check_all("R5 non-load no stall");
        idle(); mem_rd = 9; mem_wen = 1; id_rs2 = 9;
        check_all("R6 bubble cycle");
        idle(); ex_rs2 = 9; wb_rd = 9; wb_wen = 1; wb_data = 32'hcafe_f00d;
        check_all("R6 wb forward");
        idle(); id_rs1 = 9;
        check_all("R9 persist");
        // R7: same-cycle write and read
        idle(); id_rs1 = 12; id_rs2 = 12; wb_rd = 12; wb_wen = 1; wb_data = 32'h1234_5678;
        check_all("R7 write-through");
        idle(); ex_rd = 0; ex_wen = 1; ex_load = 1;
        check_all("R5 rd zero no stall");

        // Random mix over a narrow register range: R1..R9
        for (int it = 0; it < 3000; it++) begin
            id_rs1  = AW'($urandom % 8);
            id_rs2  = AW'($urandom % 8);
            ex_rs1  = AW'($urandom % 8);
            ex_rs2  = AW'($urandom % 8);
            ex_rd   = AW'($urandom % 8);
            ex_wen  = 1'($urandom);
            ex_load = 1'($urandom);
            mem_rd  = AW'($urandom % 8);
            mem_wen = 1'($urandom);
            wb_rd   = AW'($urandom % 8);
            wb_wen  = 1'($urandom);
            wb_data = $urandom;
            check_all("R1-mix random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule